// File: doc/BRIEF.md
# Memory-Module Temperature Monitor Register File

This block holds the temperature-monitoring registers of a memory-module sideband hub. A converter elsewhere delivers signed temperature samples with a one-cycle valid strobe. The block keeps the most recent sample as the current-temperature register. It compares every accepted sample with four programmable thresholds: upper, lower, critical-upper and critical-lower. It records a sticky alarm bit for each threshold that the sample crosses.

The bus front end reaches the block through a byte-wide register port. A write strobe commits one byte on the rising clock edge. Read data is combinational from the address. The port also reaches the following registers:
- a write-one-to-clear alarm register;
- a configuration bit that switches the sensor off and freezes measurement;
- constant identification bytes: device type, revision, bank and vendor codes, and capability.

Temperatures are 11-bit two's-complement counts of 0.25 °C, so the range is -256.00 °C to +255.75 °C. Each temperature sits in a 16-bit little-endian byte pair, in bits [12:2] of the word.

Top module: `tsense_regfile`

## Requirements
- R1: Address 0x00 reads 0x51, address 0x01 reads 0x18, and address 0x05 reads 0x02 when sensor support is configured: bit1 set, all other bits zero.
- R2: Address 0x02 reads the revision byte. Bits [5:4] hold major-1, bits [3:1] hold minor-1, and bits 7, 6 and 0 are zero.
- R3: Address 0x03 reads the 7-bit bank code and address 0x04 reads the 7-bit vendor code. In both bytes, bit7 is set so that the byte has an odd number of ones.
- R4: The four thresholds are byte pairs, low byte first: upper at 0x1C/0x1D, lower at 0x1E/0x1F, critical-upper at 0x20/0x21, critical-lower at 0x22/0x23.
  - A write to a low byte stores data bits [7:2] as temperature bits [5:0].
  - A write to a high byte stores data bits [4:0] as temperature bits [10:6].
  - Bits [1:0] of the low byte and bits [7:5] of the high byte always read zero.
- R5: With the sensor on, a sample strobe loads the sample into the current temperature. The current temperature reads at 0x31 (bits [5:0] in data [7:2]) and 0x32 (bits [10:6] in data [4:0]), and is visible from the next cycle.
- R6: An accepted sample sets alarm bits, read at 0x33, by signed strict comparison with each threshold:
  - bit0 when the sample is above the upper threshold;
  - bit1 when the sample is below the lower threshold;
  - bit2 when the sample is above the critical-upper threshold;
  - bit3 when the sample is below the critical-lower threshold.
  - Bits [7:4] of address 0x33 read zero.
- R7: An alarm bit stays set after later samples return inside the threshold.
- R8: Writing a mask to 0x13 clears exactly the alarm bits that are one in data [3:0]. A bit set by a sample in the same cycle stays set. Addresses 0x13 and 0x14 read zero.
- R9: Bit0 of 0x1A switches the sensor off when set. While off, samples change neither the current temperature nor the alarm bits. All other bits of 0x1A read zero.
- R10: Writes to addresses other than the thresholds, 0x13 and 0x1A have no effect, and unmapped addresses read zero.
- R11: After reset, the thresholds, current temperature, alarm bits and off bit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | New temperature sample strobe |
| sample_temp | input | 11 | Sample, two's complement, 0.25 °C units |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
The bench drives samples that sit inside all thresholds, that equal a threshold exactly, and that exceed it by one quarter degree. These patterns separate strict from non-strict comparison. Negative samples and the two range extremes expose any unsigned comparison or mis-placed sign bit. Threshold bytes are written with the padding bits set, which shows whether unused bits are masked. A clear and a sample that coincide show which of the two wins. A long pseudo-random phase mixes thresholds, masks, off periods and samples, and the outputs are compared every cycle with a behavioural model.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int TEMP_W  = 11;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int N_LIM   = 4;
    localparam int PAD_LO  = 2;
    localparam int LO_BITS = DATA_W - PAD_LO;
    localparam int HI_BITS = TEMP_W - LO_BITS;
    localparam int ALARM_W = N_LIM;

    localparam logic [ADDR_W-1:0] A_TYPE_LO = 8'h00;
    localparam logic [ADDR_W-1:0] A_TYPE_HI = 8'h01;
    localparam logic [ADDR_W-1:0] A_REV     = 8'h02;
    localparam logic [ADDR_W-1:0] A_BANK    = 8'h03;
    localparam logic [ADDR_W-1:0] A_VEND    = 8'h04;
    localparam logic [ADDR_W-1:0] A_CAP     = 8'h05;
    localparam logic [ADDR_W-1:0] A_CLR     = 8'h13;
    localparam logic [ADDR_W-1:0] A_ERRCLR  = 8'h14;
    localparam logic [ADDR_W-1:0] A_CFG     = 8'h1A;
    localparam logic [ADDR_W-1:0] A_LIMBASE = 8'h1C;
    localparam logic [ADDR_W-1:0] A_CUR_LO  = 8'h31;
    localparam logic [ADDR_W-1:0] A_CUR_HI  = 8'h32;
    localparam logic [ADDR_W-1:0] A_STAT    = 8'h33;

    localparam logic [DATA_W-1:0] TYPE_LO_VAL = 8'h51;
    localparam logic [DATA_W-1:0] TYPE_HI_VAL = 8'h18;

    typedef logic signed [TEMP_W-1:0] temp_t;

    // threshold slot order also gives the alarm bit position
    typedef enum int unsigned {
        LIM_UPPER  = 0,
        LIM_LOWER  = 1,
        LIM_CUPPER = 2,
        LIM_CLOWER = 3
    } lim_slot_e;

    typedef struct packed {
        logic clower;
        logic cupper;
        logic lower;
        logic upper;
    } alarm_t;

    typedef struct packed {
        logic [N_LIM-1:0] lim_lo;
        logic [N_LIM-1:0] lim_hi;
        logic             clr;
        logic             cfg;
    } wr_dec_t;

    function automatic logic [ADDR_W-1:0] lim_addr(input int slot, input bit hi);
        return A_LIMBASE + ADDR_W'(2 * slot) + ADDR_W'(hi);
    endfunction

    function automatic logic [DATA_W-1:0] temp_lo_byte(input temp_t t);
        return {t[LO_BITS-1:0], {PAD_LO{1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] temp_hi_byte(input temp_t t);
        return {{(DATA_W-HI_BITS){1'b0}}, t[TEMP_W-1:LO_BITS]};
    endfunction

    function automatic logic [DATA_W-1:0] odd_parity_byte(input logic [DATA_W-2:0] code);
        return {~^code, code};
    endfunction

    function automatic bit is_upper_slot(input int slot);
        return (slot == LIM_UPPER) || (slot == LIM_CUPPER);
    endfunction

    function automatic logic breached(input int slot, input temp_t s, input temp_t lim);
        if (is_upper_slot(slot)) return s > lim;
        return s < lim;
    endfunction

endpackage

// File: rtl/tsr_wr_decode.sv
module tsr_wr_decode
    import tsr_pkg::*;
(
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output wr_dec_t           dec
);
    always_comb begin
        dec = '0;
        for (int i = 0; i < N_LIM; i++) begin
            dec.lim_lo[i] = reg_wr && (reg_addr == lim_addr(i, 1'b0));
            dec.lim_hi[i] = reg_wr && (reg_addr == lim_addr(i, 1'b1));
        end
        dec.clr = reg_wr && (reg_addr == A_CLR);
        dec.cfg = reg_wr && (reg_addr == A_CFG);
    end
endmodule

// File: rtl/tsr_limit_bank.sv
module tsr_limit_bank
    import tsr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  wr_dec_t                       dec,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_LIM-1:0][TEMP_W-1:0]  lim_q
);
    for (genvar g = 0; g < N_LIM; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= '0;
            end else begin
                if (dec.lim_lo[g])
                    lim_q[g][LO_BITS-1:0] <= wdata[DATA_W-1:PAD_LO];
                if (dec.lim_hi[g])
                    lim_q[g][TEMP_W-1:LO_BITS] <= wdata[HI_BITS-1:0];
            end
        end
    end
endmodule

// File: rtl/tsr_monitor.sv
module tsr_monitor
    import tsr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sample_valid,
    input  temp_t                         sample_temp,
    input  logic [N_LIM-1:0][TEMP_W-1:0]  lim_q,
    input  logic                          clr_we,
    input  logic                          cfg_we,
    input  logic [DATA_W-1:0]             wdata,
    output temp_t                         cur_q,
    output alarm_t                        status_q,
    output logic                          off_q
);
    logic [N_LIM-1:0] hit;
    logic             accept;
    alarm_t           status_nxt;

    assign accept = sample_valid && !off_q;

    for (genvar g = 0; g < N_LIM; g++) begin : g_cmp
        assign hit[g] = breached(g, sample_temp, temp_t'(lim_q[g]));
    end

    // clear first, then a fresh crossing in the same cycle wins
    always_comb begin
        status_nxt = status_q;
        if (clr_we)
            status_nxt = status_nxt & ~alarm_t'(wdata[ALARM_W-1:0]);
        if (accept)
            status_nxt = status_nxt | alarm_t'(hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            status_q <= '0;
            off_q    <= 1'b0;
        end else begin
            if (accept)
                cur_q <= sample_temp;
            status_q <= status_nxt;
            if (cfg_we)
                off_q <= wdata[0];
        end
    end
endmodule

// File: rtl/tsr_read_mux.sv
module tsr_read_mux
    import tsr_pkg::*;
#(
    parameter logic [DATA_W-2:0] BANK_CODE   = 7'h04,
    parameter logic [DATA_W-2:0] VENDOR_CODE = 7'h33,
    parameter int                REV_MAJOR   = 2,
    parameter int                REV_MINOR   = 1,
    parameter bit                TS_SUPPORT  = 1'b1
)(
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [N_LIM-1:0][TEMP_W-1:0]  lim_q,
    input  temp_t                         cur_q,
    input  alarm_t                        status_q,
    input  logic                          off_q,
    output logic [DATA_W-1:0]             rdata
);
    localparam logic [1:0] MAJ_F = 2'(REV_MAJOR - 1);
    localparam logic [2:0] MIN_F = 3'(REV_MINOR - 1);
    localparam logic [DATA_W-1:0] REV_BYTE = {2'b00, MAJ_F, MIN_F, 1'b0};
    localparam logic [DATA_W-1:0] CAP_BYTE = {6'b0, TS_SUPPORT, 1'b0};

    always_comb begin
        rdata = '0;
        unique case (reg_addr)
            A_TYPE_LO: rdata = TYPE_LO_VAL;
            A_TYPE_HI: rdata = TYPE_HI_VAL;
            A_REV:     rdata = REV_BYTE;
            A_BANK:    rdata = odd_parity_byte(BANK_CODE);
            A_VEND:    rdata = odd_parity_byte(VENDOR_CODE);
            A_CAP:     rdata = CAP_BYTE;
            A_CFG:     rdata = {{(DATA_W-1){1'b0}}, off_q};
            A_CUR_LO:  rdata = temp_lo_byte(cur_q);
            A_CUR_HI:  rdata = temp_hi_byte(cur_q);
            A_STAT:    rdata = {{(DATA_W-ALARM_W){1'b0}}, status_q};
            default: begin
                for (int i = 0; i < N_LIM; i++) begin
                    if (reg_addr == lim_addr(i, 1'b0)) rdata = temp_lo_byte(temp_t'(lim_q[i]));
                    if (reg_addr == lim_addr(i, 1'b1)) rdata = temp_hi_byte(temp_t'(lim_q[i]));
                end
            end
        endcase
    end
endmodule

// File: rtl/tsense_regfile.sv
module tsense_regfile
    import tsr_pkg::*;
#(
    parameter logic [6:0] BANK_CODE   = 7'h04,
    parameter logic [6:0] VENDOR_CODE = 7'h33,
    parameter int         REV_MAJOR   = 2,
    parameter int         REV_MINOR   = 1,
    parameter bit         TS_SUPPORT  = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_valid,
    input  logic [10:0]       sample_temp,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    wr_dec_t                         dec;
    logic [N_LIM-1:0][TEMP_W-1:0]    lim_q;
    temp_t                           cur_temp;
    alarm_t                          alarm_st;
    logic                            sensor_off;

    tsr_wr_decode u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .dec      (dec)
    );

    tsr_limit_bank u_lim (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .wdata (reg_wdata),
        .lim_q (lim_q)
    );

    tsr_monitor u_mon (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_temp  (temp_t'(sample_temp)),
        .lim_q        (lim_q),
        .clr_we       (dec.clr),
        .cfg_we       (dec.cfg),
        .wdata        (reg_wdata),
        .cur_q        (cur_temp),
        .status_q     (alarm_st),
        .off_q        (sensor_off)
    );

    tsr_read_mux #(
        .BANK_CODE   (BANK_CODE),
        .VENDOR_CODE (VENDOR_CODE),
        .REV_MAJOR   (REV_MAJOR),
        .REV_MINOR   (REV_MINOR),
        .TS_SUPPORT  (TS_SUPPORT)
    ) u_rd (
        .reg_addr (reg_addr),
        .lim_q    (lim_q),
        .cur_q    (cur_temp),
        .status_q (alarm_st),
        .off_q    (sensor_off),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker (
    input logic        clk,
    input logic        rst,
    input logic        sample_valid,
    input logic [10:0] sample_temp,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [7:0]  reg_rdata,
    input logic [10:0] cur_temp,
    input logic [3:0]  alarm_bits,
    input logic        sensor_off
);
    AST_TYPE_BYTE: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h00) |-> (reg_rdata == 8'h51)); // R1

    AST_ID_PARITY: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr == 8'h03) || (reg_addr == 8'h04)) |-> (^reg_rdata == 1'b1)); // R3

    AST_LIMIT_PAD: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr >= 8'h1C) && (reg_addr <= 8'h23) && !reg_addr[0]) |-> (reg_rdata[1:0] == 2'b00)); // R4

    AST_SAMPLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !sensor_off) |=> (cur_temp == $past(sample_temp))); // R5

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|($past(alarm_bits) & ~alarm_bits)) |-> $past(reg_wr && (reg_addr == 8'h13))); // R7

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h13) |-> (reg_rdata == 8'h00)); // R8

    AST_OFF_FREEZE: assert property (@(posedge clk) disable iff (rst)
        sensor_off |=> $stable(cur_temp)); // R9

    AST_OFF_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
        sensor_off |=> ((alarm_bits & ~$past(alarm_bits)) == 4'b0000)); // R9
endmodule

bind tsense_regfile tsr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .sample_temp  (sample_temp),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .cur_temp     (cur_temp),
    .alarm_bits   (alarm_st),
    .sensor_off   (sensor_off)
);

// File: tb/tsense_regfile_test.sv
module tsense_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] T_BANK = 7'h04;
    localparam logic [6:0] T_VEND = 7'h33;
    localparam int T_MAJ = 2;
    localparam int T_MIN = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [10:0] sample_temp = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;

    int vectors = 0;
    int miscompares = 0;
    string phase = "R11 reset";

    logic signed [10:0] m_lim [4];
    logic signed [10:0] m_cur;
    logic [3:0]         m_stat;
    bit                 m_off;

    tsense_regfile uut (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_temp  (sample_temp),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] id_byte(logic [6:0] code);
        int ones = 0;
        for (int i = 0; i < 7; i++) ones += code[i];
        return {(ones % 2 == 0) ? 1'b1 : 1'b0, code};
    endfunction

    function automatic string req_of(logic [7:0] a);
        if (a == 8'h00 || a == 8'h01 || a == 8'h05) return "R1";
        if (a == 8'h02) return "R2";
        if (a == 8'h03 || a == 8'h04) return "R3";
        if (a >= 8'h1C && a <= 8'h23) return "R4";
        if (a == 8'h31 || a == 8'h32) return "R5";
        if (a == 8'h33) return "R6";
        if (a == 8'h13 || a == 8'h14) return "R8";
        if (a == 8'h1A) return "R9";
        return "R10";
    endfunction

    function automatic logic [7:0] model_read(logic [7:0] a);
        int slot;
        case (a)
            8'h00: return 8'h51;
            8'h01: return 8'h18;
            8'h02: return 8'((T_MAJ - 1) * 16 + (T_MIN - 1) * 2);
            8'h03: return id_byte(T_BANK);
            8'h04: return id_byte(T_VEND);
            8'h05: return 8'h02;
            8'h1A: return {7'b0, m_off};
            8'h31: return {m_cur[5:0], 2'b00};
            8'h32: return {3'b000, m_cur[10:6]};
            8'h33: return {4'b0000, m_stat};
            default: begin
                if (a >= 8'h1C && a <= 8'h23) begin
                    slot = (int'(a) - 'h1C) / 2;
                    if (a[0]) return {3'b000, m_lim[slot][10:6]};
                    return {m_lim[slot][5:0], 2'b00};
                end
                return 8'h00;
            end
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_lim[i] = '0;
        m_cur = '0;
        m_stat = '0;
        m_off = 1'b0;
    endtask

    task automatic model_step(bit we, logic [7:0] a, logic [7:0] d, bit sv, logic signed [10:0] t);
        logic [3:0] ns = m_stat;
        bit take = sv && !m_off;
        int slot;
        if (we && a == 8'h13) ns = ns & ~d[3:0];
        if (take) begin
            if (t > m_lim[0]) ns[0] = 1'b1;
            if (t < m_lim[1]) ns[1] = 1'b1;
            if (t > m_lim[2]) ns[2] = 1'b1;
            if (t < m_lim[3]) ns[3] = 1'b1;
            m_cur = t;
        end
        m_stat = ns;
        if (we && a >= 8'h1C && a <= 8'h23) begin
            slot = (int'(a) - 'h1C) / 2;
            if (a[0]) m_lim[slot][10:6] = d[4:0];
            else      m_lim[slot][5:0]  = d[7:2];
        end
        if (we && a == 8'h1A) m_off = d[0];
    endtask

    task automatic compare();
        logic [7:0] exp = model_read(reg_addr);
        vectors++;
        if (reg_rdata !== exp) begin
            miscompares++;
            $display("FAIL %s [%s] addr %02h got %02h expected %02h",
                     req_of(reg_addr), phase, reg_addr, reg_rdata, exp);
        end
    endtask

    task automatic cycle(bit we, logic [7:0] a, logic [7:0] d, bit sv, logic signed [10:0] t);
        @(negedge clk);
        compare();
        reg_wr = we; reg_addr = a; reg_wdata = d;
        sample_valid = sv; sample_temp = t;
        @(posedge clk);
        model_step(we, a, d, sv, t);
    endtask

    task automatic rd(logic [7:0] a);
        cycle(1'b0, a, 8'h00, 1'b0, '0);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cycle(1'b1, a, d, 1'b0, '0);
    endtask

    task automatic smp(int q);
        cycle(1'b0, 8'h33, 8'h00, 1'b1, 11'(q));
    endtask

    // padding bits are deliberately set to show they are dropped
    task automatic wr_limit(int slot, int q);
        logic [10:0] b = 11'(q);
        wr(8'(8'h1C + 2 * slot), {b[5:0], 2'b11});
        wr(8'(8'h1D + 2 * slot), {3'b111, b[10:6]});
        rd(8'(8'h1C + 2 * slot));
        rd(8'(8'h1D + 2 * slot));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog (all requirements) got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        phase = "R11 reset";
        foreach (m_lim[i]) begin
            rd(8'(8'h1C + 2 * i));
            rd(8'(8'h1D + 2 * i));
        end
        rd(8'h31); rd(8'h32); rd(8'h33); rd(8'h1A);

        phase = "R1 R2 R3 identification";
        for (int a = 0; a < 6; a++) rd(8'(a));

        phase = "R4 thresholds";
        wr_limit(0, 200);
        wr_limit(1, 40);
        wr_limit(2, 340);
        wr_limit(3, -80);

        phase = "R5 R6 in range";
        smp(100); rd(8'h31); rd(8'h32); rd(8'h33);
        phase = "R6 equal to upper is no alarm";
        smp(200); rd(8'h33);
        phase = "R6 one step above upper";
        smp(201); rd(8'h33);
        phase = "R6 critical upper";
        smp(360); rd(8'h31); rd(8'h32);
        phase = "R7 sticky after return";
        smp(100); rd(8'h33);
        phase = "R8 partial clear";
        wr(8'h13, 8'h01); rd(8'h33);
        phase = "R6 negative samples";
        smp(-30); smp(-81); rd(8'h31); rd(8'h32); rd(8'h33);
        phase = "R6 range extremes";
        wr(8'h13, 8'hFF);
        smp(1023); rd(8'h32); smp(-1024); rd(8'h32); rd(8'h33);
        phase = "R8 clear colliding with set";
        wr(8'h13, 8'hFF);
        cycle(1'b1, 8'h13, 8'h0F, 1'b1, 11'(250));
        rd(8'h33); rd(8'h14);

        phase = "R9 sensor off";
        wr(8'h1A, 8'hFF); rd(8'h1A);
        wr(8'h13, 8'h0F);
        smp(500); smp(-500); rd(8'h31); rd(8'h32); rd(8'h33);
        wr(8'h1A, 8'h00); rd(8'h1A);
        smp(12); rd(8'h31);

        phase = "R10 ignored writes";
        wr(8'h00, 8'hAA); wr(8'h05, 8'hFF); wr(8'h31, 8'h55);
        wr(8'h32, 8'h1F); wr(8'h33, 8'h00); wr(8'h14, 8'hFF); wr(8'h40, 8'h12);
        rd(8'h00); rd(8'h05); rd(8'h31); rd(8'h32); rd(8'h33);
        rd(8'h14); rd(8'h40); rd(8'hFF);

        phase = "R6 R8 R9 mixed";
        for (int n = 0; n < 2000; n++) begin
            int pick = $urandom_range(0, 9);
            logic [7:0] rnd = 8'($urandom);
            case (pick)
                0: wr(8'(8'h1C + $urandom_range(0, 7)), rnd);
                1: wr(8'h13, rnd);
                2: wr(8'h1A, ($urandom_range(0, 7) == 0) ? rnd : 8'h00);
                3, 4, 5: cycle(1'b0, 8'(8'h1C + $urandom_range(0, 23)), 8'h00, 1'b1, 11'($urandom));
                6: cycle(1'b1, 8'h13, rnd, 1'b1, 11'($urandom));
                default: rd(8'h33);
            endcase
        end
        rd(8'h31);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule